// File: doc/BRIEF.md
# Scalar Clock Race Comparator

This block keeps the scalar logical clock of one software thread and decides, for each shared-memory access the thread makes, whether the access was already ordered after a conflicting earlier access. The earlier access is identified by its timestamp. If the access was not ordered, the block flags an ordering race so that the outcome can be logged for deterministic replay. When the access is a data access that lies too close in logical time to the conflicting one, the block also reports a data race. Each cycle the block chooses the new clock value as the largest of several candidates. Those candidates come from the race update, a synchronization read, a synchronization write and a thread migration.

The comparison uses a runtime window `D`, which widens the distance that counts as synchronized. A synchronization read moves the clock to at least the conflicting write timestamp plus `D`. A migration of the thread onto a processor adds `D` to the clock. The race update and the synchronization-write increment each move the clock by one. A timestamp taken from main memory, rather than from a cache line, can still order the clock but never produces a data-race report. Each time the clock changes, a strobe carrying the previous clock value is raised for one cycle, so that a logger can record the step.

All results are registered. An access or a migration presented in one cycle is reflected on the outputs after the next rising clock edge.

Top module: `sclk_race_cmp`

## Requirements
- R1: While reset is asserted and after reset is released, the clock output is 0 and the ordering-race, data-race and change-strobe outputs are low.
- R2: An access with a valid conflicting timestamp raises the ordering-race output in the next cycle when the current clock is less than or equal to that timestamp, and the clock becomes at least the timestamp plus one. For a data access with no migration, the clock becomes exactly the timestamp plus one.
- R3: A data access whose valid timestamp is lower than the clock raises no ordering race and leaves the clock unchanged.
- R4: A synchronization read (kind code 2'b10) with a valid timestamp sets the clock to the larger of its current value and the timestamp plus the effective window.
- R5: A synchronization write (kind code 2'b11) increases the clock by one, unless a larger candidate applies. Data reads (2'b00) and data writes (2'b01) never increase the clock by themselves.
- R6: A data access with a valid timestamp that is not from main memory reports a data race in the next cycle when clock minus timestamp is less than the effective window. This includes the case where the clock is at or below the timestamp. At a distance equal to the window, no data race is reported.
- R7: A timestamp flagged as coming from main memory never produces a data-race report, but it still updates the clock and raises the ordering race.
- R8: Synchronization accesses never report a data race.
- R9: A migration event adds the effective window to the clock. When a migration and an access occur in the same cycle, the clock becomes the maximum of all applicable candidates.
- R10: The effective window is the input window limited to the range 1 to 256: an input of 0 acts as 1, and any input above 256 acts as 256.
- R11: In the cycle after the clock changes, the change strobe is high and the previous-value output holds the clock value from before the change. The strobe is low in every other cycle.
- R12: The clock saturates at 65535 and never wraps.
- R13: A cycle with no access and no migration leaves the clock unchanged and the race outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_kind_i | input | 2 | Access kind: bit 1 set for synchronization, bit 0 set for write |
| ts_valid_i | input | 1 | A conflicting timestamp is supplied |
| ts_value_i | input | 16 | Conflicting access timestamp |
| ts_from_mem_i | input | 1 | The timestamp is the shared main-memory timestamp |
| migrate_i | input | 1 | The thread starts running on a processor this cycle |
| win_d_i | input | 9 | Synchronization window D, clamped to 1..256 |
| order_race_o | output | 1 | Ordering race found by the previous cycle's access |
| data_race_o | output | 1 | Data race report for the previous cycle's access |
| clock_o | output | 16 | Current logical clock of the thread |
| chg_stb_o | output | 1 | One-cycle strobe after a clock change |
| chg_prev_o | output | 16 | Clock value before the latest change |

## Verification
A wrong internal clock value shows up in the cycle right after the access that updated it, because `clock_o` is the state register itself. The same error then changes the race verdicts of every later access. A wrong candidate selection or a wrong window clamp becomes visible only when the access that follows lands near the boundary. For that reason, the directed sequences probe distances equal to D and D−1, combined updates, and saturation. An error in the strobe appears in that same next cycle as a mismatch between `chg_prev_o` and the clock value observed one cycle before.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

   // Access kind: bit 1 = synchronization, bit 0 = write.
   typedef enum logic [1:0] {
      ACC_DATA_RD = 2'b00,
      ACC_DATA_WR = 2'b01,
      ACC_SYNC_RD = 2'b10,
      ACC_SYNC_WR = 2'b11
   } acc_kind_e;

   // Candidate slots feeding the maximum selector.
   localparam int unsigned CAND_N    = 5;
   localparam int unsigned CI_HOLD   = 0;
   localparam int unsigned CI_ORDER  = 1;
   localparam int unsigned CI_SYNCRD = 2;
   localparam int unsigned CI_SYNCWR = 3;
   localparam int unsigned CI_MIGR   = 4;

endpackage

// File: rtl/sclk_win_clamp.sv
module sclk_win_clamp #(
   parameter int unsigned WIN_W = 9,
   parameter int unsigned D_MAX = 256
) (
   input  logic [WIN_W-1:0] d_raw,
   output logic [WIN_W-1:0] d_eff
);
   localparam logic [WIN_W-1:0] D_ONE   = {{(WIN_W-1){1'b0}}, 1'b1};
   localparam logic [WIN_W-1:0] D_TOP   = WIN_W'(D_MAX);
   // The upper clamp is only built when the field can encode values above D_MAX.
   localparam bit               NEED_HI = ((2 ** WIN_W) - 1) > D_MAX;

   generate
      if (NEED_HI) begin : g_clamp_both
         always_comb begin
            if (d_raw == '0)        d_eff = D_ONE;
            else if (d_raw > D_TOP) d_eff = D_TOP;
            else                    d_eff = d_raw;
         end
      end else begin : g_clamp_low
         always_comb begin
            if (d_raw == '0) d_eff = D_ONE;
            else             d_eff = d_raw;
         end
      end
   endgenerate
endmodule

// File: rtl/sclk_race_eval.sv
module sclk_race_eval
   import sclk_pkg::*;
#(
   parameter int unsigned CLK_W = 16,
   parameter int unsigned WIN_W = 9,
   parameter int unsigned EXT_W = CLK_W + 1
) (
   input  logic                           acc_valid,
   input  logic [1:0]                     acc_kind,
   input  logic                           ts_valid,
   input  logic [CLK_W-1:0]               ts_value,
   input  logic                           ts_from_mem,
   input  logic                           migrate,
   input  logic [WIN_W-1:0]               d_eff,
   input  logic [CLK_W-1:0]               clock_q,
   output logic                           order_race,
   output logic                           data_race,
   output logic [CAND_N-1:0][EXT_W-1:0]   cand
);
   logic             conflict;
   logic             not_after;
   logic             in_window;
   logic             is_sync_rd;
   logic             is_sync_wr;
   logic             is_data;
   logic [CLK_W-1:0] gap;
   logic [CLK_W-1:0] d_wide;
   logic [EXT_W-1:0] clk_x;
   logic [EXT_W-1:0] ts_x;
   logic [EXT_W-1:0] d_x;

   always_comb begin
      is_sync_rd = (acc_kind == ACC_SYNC_RD);
      is_sync_wr = (acc_kind == ACC_SYNC_WR);
      is_data    = (acc_kind == ACC_DATA_RD) || (acc_kind == ACC_DATA_WR);
      conflict   = acc_valid && ts_valid;

      // Ordering test: the thread is not yet past the conflicting access.
      not_after  = (clock_q <= ts_value);
      order_race = conflict && not_after;

      // Window test: one subtraction and one compare.
      gap        = clock_q - ts_value;
      d_wide     = {{(CLK_W-WIN_W){1'b0}}, d_eff};
      in_window  = not_after || (gap < d_wide);
      data_race  = conflict && is_data && !ts_from_mem && in_window;

      // Candidates are one bit wider so that sums cannot wrap before saturation.
      clk_x = {1'b0, clock_q};
      ts_x  = {1'b0, ts_value};
      d_x   = {{(EXT_W-WIN_W){1'b0}}, d_eff};

      cand[CI_HOLD]   = clk_x;
      cand[CI_ORDER]  = order_race                            ? (ts_x + EXT_W'(1))  : '0;
      cand[CI_SYNCRD] = (acc_valid && ts_valid && is_sync_rd) ? (ts_x + d_x)        : '0;
      cand[CI_SYNCWR] = (acc_valid && is_sync_wr)             ? (clk_x + EXT_W'(1)) : '0;
      cand[CI_MIGR]   = migrate                               ? (clk_x + d_x)       : '0;
   end
endmodule

// File: rtl/sclk_max_sel.sv
module sclk_max_sel #(
   parameter int unsigned N = 5,
   parameter int unsigned W = 17
) (
   input  logic [N-1:0][W-1:0] vals,
   output logic [W-1:0]        max_o
);
   always_comb begin
      max_o = vals[0];
      for (int i = 1; i < N; i++) begin
         if (vals[i] > max_o) max_o = vals[i];
      end
   end
endmodule

// File: rtl/sclk_race_cmp.sv
module sclk_race_cmp
   import sclk_pkg::*;
#(
   parameter int unsigned CLK_W = 16,
   parameter int unsigned WIN_W = 9,
   parameter int unsigned D_MAX = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid_i,
   input  logic [1:0]       acc_kind_i,
   input  logic             ts_valid_i,
   input  logic [CLK_W-1:0] ts_value_i,
   input  logic             ts_from_mem_i,
   input  logic             migrate_i,
   input  logic [WIN_W-1:0] win_d_i,
   output logic             order_race_o,
   output logic             data_race_o,
   output logic [CLK_W-1:0] clock_o,
   output logic             chg_stb_o,
   output logic [CLK_W-1:0] chg_prev_o
);
   localparam int unsigned EXT_W = CLK_W + 1;

   initial begin : p_param_chk
      assert (CLK_W >= 4) else $fatal(1, "clock width too small");
      assert (WIN_W < CLK_W) else $fatal(1, "window field must be narrower than clock");
      assert (D_MAX >= 1 && D_MAX < (2 ** WIN_W)) else $fatal(1, "window limit out of field range");
   end

   logic [WIN_W-1:0]             d_eff;
   logic                         order_race;
   logic                         data_race;
   logic [CAND_N-1:0][EXT_W-1:0] cand;
   logic [EXT_W-1:0]             next_ext;
   logic [CLK_W-1:0]             next_clk;
   logic [CLK_W-1:0]             clock_q;

   sclk_win_clamp #(.WIN_W(WIN_W), .D_MAX(D_MAX)) u_clamp (
      .d_raw (win_d_i),
      .d_eff (d_eff)
   );

   sclk_race_eval #(.CLK_W(CLK_W), .WIN_W(WIN_W), .EXT_W(EXT_W)) u_eval (
      .acc_valid   (acc_valid_i),
      .acc_kind    (acc_kind_i),
      .ts_valid    (ts_valid_i),
      .ts_value    (ts_value_i),
      .ts_from_mem (ts_from_mem_i),
      .migrate     (migrate_i),
      .d_eff       (d_eff),
      .clock_q     (clock_q),
      .order_race  (order_race),
      .data_race   (data_race),
      .cand        (cand)
   );

   sclk_max_sel #(.N(CAND_N), .W(EXT_W)) u_max (
      .vals  (cand),
      .max_o (next_ext)
   );

   // Saturate at the top of the clock range instead of wrapping.
   assign next_clk = next_ext[CLK_W] ? {CLK_W{1'b1}} : next_ext[CLK_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clock_q      <= '0;
         order_race_o <= 1'b0;
         data_race_o  <= 1'b0;
         chg_stb_o    <= 1'b0;
         chg_prev_o   <= '0;
      end else begin
         clock_q      <= next_clk;
         order_race_o <= order_race;
         data_race_o  <= data_race;
         chg_stb_o    <= (next_clk != clock_q);
         if (next_clk != clock_q) chg_prev_o <= clock_q;
      end
   end

   assign clock_o = clock_q;
endmodule

// File: rtl/sclk_race_cmp_chk.sv
module sclk_race_cmp_chk #(
   parameter int unsigned CLK_W = 16,
   parameter int unsigned WIN_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid_i,
   input logic [1:0]       acc_kind_i,
   input logic             ts_valid_i,
   input logic [CLK_W-1:0] ts_value_i,
   input logic             ts_from_mem_i,
   input logic             migrate_i,
   input logic [WIN_W-1:0] win_d_i,
   input logic             order_race_o,
   input logic             data_race_o,
   input logic [CLK_W-1:0] clock_o,
   input logic             chg_stb_o,
   input logic [CLK_W-1:0] chg_prev_o
);
   localparam logic [CLK_W-1:0] MAX_CLK = {CLK_W{1'b1}};

   // R2 / R12: the clock never moves backwards.
   p_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> clock_o >= $past(clock_o));

   // R3: an access already ordered after its conflict leaves the clock alone.
   p_ordered_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && !acc_kind_i[1] && ts_valid_i && clock_o > ts_value_i && !migrate_i)
      |=> !order_race_o && $stable(clock_o));

   // R5: a synchronization write advances an unsaturated clock.
   p_sync_wr_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && acc_kind_i == 2'b11 && clock_o != MAX_CLK) |=> clock_o > $past(clock_o));

   // R7: main-memory timestamps never produce a data-race report.
   p_mem_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && ts_from_mem_i) |=> !data_race_o);

   // R8: synchronization accesses never produce a data-race report.
   p_sync_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && acc_kind_i[1]) |=> !data_race_o);

   // R9: a migration always advances an unsaturated clock (window is at least 1).
   p_migrate_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (migrate_i && clock_o != MAX_CLK && win_d_i != '0) |=> clock_o > $past(clock_o));

   // R11: every clock change is announced with the prior value.
   p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clock_o != $past(clock_o)) |-> (chg_stb_o && chg_prev_o == $past(clock_o)));

   p_strobe_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
      chg_stb_o |-> chg_prev_o < clock_o);

   // R13: idle cycles change nothing.
   p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid_i && !migrate_i) |=> ($stable(clock_o) && !order_race_o && !data_race_o));
endmodule

bind sclk_race_cmp sclk_race_cmp_chk #(.CLK_W(CLK_W), .WIN_W(WIN_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .acc_valid_i   (acc_valid_i),
   .acc_kind_i    (acc_kind_i),
   .ts_valid_i    (ts_valid_i),
   .ts_value_i    (ts_value_i),
   .ts_from_mem_i (ts_from_mem_i),
   .migrate_i     (migrate_i),
   .win_d_i       (win_d_i),
   .order_race_o  (order_race_o),
   .data_race_o   (data_race_o),
   .clock_o       (clock_o),
   .chg_stb_o     (chg_stb_o),
   .chg_prev_o    (chg_prev_o)
);

// File: tb/sclk_race_cmp_tb_top.sv
`timescale 1ns/1ps
module sclk_race_cmp_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid_i = 1'b0;
   logic [1:0]  acc_kind_i = 2'b00;
   logic        ts_valid_i = 1'b0;
   logic [15:0] ts_value_i = 16'd0;
   logic        ts_from_mem_i = 1'b0;
   logic        migrate_i = 1'b0;
   logic [8:0]  win_d_i = 9'd4;
   logic        order_race_o;
   logic        data_race_o;
   logic [15:0] clock_o;
   logic        chg_stb_o;
   logic [15:0] chg_prev_o;

   int n_chk  = 0;
   int n_fail = 0;

   localparam logic [1:0] K_DRD = 2'b00;
   localparam logic [1:0] K_DWR = 2'b01;
   localparam logic [1:0] K_SRD = 2'b10;
   localparam logic [1:0] K_SWR = 2'b11;

   always #10 clk = ~clk;

   sclk_race_cmp dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .acc_valid_i   (acc_valid_i),
      .acc_kind_i    (acc_kind_i),
      .ts_valid_i    (ts_valid_i),
      .ts_value_i    (ts_value_i),
      .ts_from_mem_i (ts_from_mem_i),
      .migrate_i     (migrate_i),
      .win_d_i       (win_d_i),
      .order_race_o  (order_race_o),
      .data_race_o   (data_race_o),
      .clock_o       (clock_o),
      .chg_stb_o     (chg_stb_o),
      .chg_prev_o    (chg_prev_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Called at a falling edge: drive one cycle, let the rising edge capture it,
   // return at the next falling edge with inputs idle and outputs settled.
   task automatic step(input logic av, input logic [1:0] kind, input logic tv,
                       input logic [15:0] ts, input logic mem, input logic mig,
                       input logic [8:0] d);
      acc_valid_i   = av;
      acc_kind_i    = kind;
      ts_valid_i    = tv;
      ts_value_i    = ts;
      ts_from_mem_i = mem;
      migrate_i     = mig;
      win_d_i       = d;
      @(posedge clk);
      @(negedge clk);
      acc_valid_i   = 1'b0;
      ts_valid_i    = 1'b0;
      ts_from_mem_i = 1'b0;
      migrate_i     = 1'b0;
   endtask

   task automatic expect_out(input string req, input int clk_e, input int ord_e,
                             input int dr_e, input int stb_e);
      check(req, "clock", int'(clock_o), clk_e);
      check(req, "order_race", int'(order_race_o), ord_e);
      check(req, "data_race", int'(data_race_o), dr_e);
      check(req, "chg_stb", int'(chg_stb_o), stb_e);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      @(negedge clk);
      expect_out("R1", 0, 0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_out("R1", 0, 0, 0, 0);
   endtask

   task automatic t_sync_write_and_idle;
      step(1'b1, K_SWR, 1'b0, 16'd0, 1'b0, 1'b0, 9'd4);
      expect_out("R5", 1, 0, 0, 1);
      check("R11", "chg_prev", int'(chg_prev_o), 0);
      step(1'b0, K_DRD, 1'b0, 16'd0, 1'b0, 1'b0, 9'd4);
      expect_out("R13", 1, 0, 0, 0);
      step(1'b1, K_DRD, 1'b0, 16'd0, 1'b0, 1'b0, 9'd4);
      expect_out("R5", 1, 0, 0, 0);
      step(1'b1, K_DWR, 1'b0, 16'd0, 1'b0, 1'b0, 9'd4);
      expect_out("R5", 1, 0, 0, 0);
   endtask

   task automatic t_order_race;
      step(1'b1, K_DRD, 1'b1, 16'd10, 1'b0, 1'b0, 9'd4);
      expect_out("R2", 11, 1, 1, 1);
      check("R11", "chg_prev", int'(chg_prev_o), 1);
      step(1'b1, K_DWR, 1'b1, 16'd3, 1'b0, 1'b0, 9'd4);
      expect_out("R3", 11, 0, 0, 0);
   endtask

   task automatic t_window;
      step(1'b1, K_DRD, 1'b1, 16'd8, 1'b0, 1'b0, 9'd4);
      expect_out("R6", 11, 0, 1, 0);
      step(1'b1, K_DWR, 1'b1, 16'd7, 1'b0, 1'b0, 9'd4);
      expect_out("R6", 11, 0, 0, 0);
   endtask

   task automatic t_mem_suppress;
      step(1'b1, K_DRD, 1'b1, 16'd20, 1'b1, 1'b0, 9'd4);
      expect_out("R7", 21, 1, 0, 1);
   endtask

   task automatic t_sync_read;
      step(1'b1, K_SRD, 1'b1, 16'd30, 1'b0, 1'b0, 9'd4);
      expect_out("R4", 34, 1, 0, 1);
      step(1'b1, K_SRD, 1'b1, 16'd10, 1'b0, 1'b0, 9'd4);
      expect_out("R4", 34, 0, 0, 0);
      step(1'b1, K_SWR, 1'b1, 16'd40, 1'b0, 1'b0, 9'd4);
      expect_out("R8", 41, 1, 0, 1);
   endtask

   task automatic t_migrate;
      step(1'b0, K_DRD, 1'b0, 16'd0, 1'b0, 1'b1, 9'd4);
      expect_out("R9", 45, 0, 0, 1);
      step(1'b1, K_SWR, 1'b0, 16'd0, 1'b0, 1'b1, 9'd4);
      expect_out("R9", 49, 0, 0, 1);
      step(1'b1, K_DRD, 1'b1, 16'd60, 1'b0, 1'b1, 9'd4);
      expect_out("R9", 61, 1, 1, 1);
   endtask

   task automatic t_clamp;
      step(1'b0, K_DRD, 1'b0, 16'd0, 1'b0, 1'b1, 9'd0);
      expect_out("R10", 62, 0, 0, 1);
      step(1'b0, K_DRD, 1'b0, 16'd0, 1'b0, 1'b1, 9'd300);
      expect_out("R10", 318, 0, 0, 1);
      step(1'b1, K_SRD, 1'b1, 16'd400, 1'b0, 1'b0, 9'd256);
      expect_out("R10", 656, 1, 0, 1);
      step(1'b1, K_DRD, 1'b1, 16'd400, 1'b0, 1'b0, 9'd300);
      expect_out("R10", 656, 0, 0, 0);
      step(1'b1, K_DRD, 1'b1, 16'd401, 1'b0, 1'b0, 9'd300);
      expect_out("R10", 656, 0, 1, 0);
   endtask

   task automatic t_saturate;
      step(1'b1, K_DWR, 1'b1, 16'd65535, 1'b0, 1'b0, 9'd4);
      expect_out("R12", 65535, 1, 1, 1);
      check("R11", "chg_prev", int'(chg_prev_o), 656);
      step(1'b1, K_SWR, 1'b0, 16'd0, 1'b0, 1'b0, 9'd4);
      expect_out("R12", 65535, 0, 0, 0);
      step(1'b0, K_DRD, 1'b0, 16'd0, 1'b0, 1'b1, 9'd256);
      expect_out("R12", 65535, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      t_reset();
      t_sync_write_and_idle();
      t_order_race();
      t_window();
      t_mem_suppress();
      t_sync_read();
      t_migrate();
      t_clamp();
      t_saturate();
      t_reset();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule